// File: doc/BRIEF.md
# Synchronous Serial Transmit Engine

This block is the transmit half of a clocked synchronous serial port. A host writes a byte into a holding register. When the shifter is free, the engine copies the byte into a shift register and sends it as an 8-bit frame on `sdo`. It keeps two flags. `tde` says the holding register is free to take a new byte. `tend` says the last frame has finished and nothing was waiting behind it. Each flag can raise an interrupt request through its own enable.

The engine runs in one of two roles. As clock master it makes the serial clock from the system clock. Each half of the serial clock lasts `div_half` system cycles. As a slave it drives data only while the active-low select is low, and it advances on edges of an external clock. Both the external clock and the select pass through a synchroniser.

Serial clock rules:
- The clock idles at a level chosen by `clk_pol`.
- A receiver takes each bit when the clock leaves its idle level.
- The next bit appears when the clock returns to idle.

A byte waiting at the end of a frame starts the next frame with no gap. While the overrun input is high, no frame starts.

Top module: `sstx_engine`

## Requirements
- R1: In master mode `sclk_oe` and `sdo_oe` are 1. Each half of the serial clock lasts `div_half` system cycles, and a `div_half` of 0 acts as 1.
- R2: A write (`wr_en`=1) clears `tde` to 0 at that clock edge. When a frame may start, the byte moves into the shift register at the next edge and `tde` returns to 1.
- R3: `txi_irq` is 1 exactly while `tde`=1 and `tx_ie`=1.
- R4: The frame is 8 bits. With `lsb_first`=0 bit 7 goes first, and with `lsb_first`=1 bit 0 goes first. Each bit is valid when the serial clock leaves its idle level and is replaced when the clock returns to idle.
- R5: If `tde`=1 when the 8th bit completes, `tend` becomes 1. It holds until `tend_clr` or a write clears it.
- R6: `tei_irq` is 1 exactly while `tend`=1 and `tend_ie`=1.
- R7: Outside a frame the serial clock rests high when `clk_pol`=0 and low when `clk_pol`=1.
- R8: If a byte is waiting (`tde`=0) when a frame completes, the next frame follows at once. `tend` stays 0 in that case.
- R9: While `ovr_flag`=1 no frame starts, the serial clock stays idle, and a written byte keeps `tde` at 0.
- R10: In slave mode `sclk_oe`=0. A frame starts only while `sel_n` is low, bits advance on the external clock's returns to idle, and `sdo_oe` follows the inverse of the synchronised `sel_n`.
- R11: In slave mode, raising `sel_n` mid-frame ends the frame without setting `tend`. The next frame starts again from its first bit.
- R12: After reset `tde`=1, `tend`=0, and the serial clock rests at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to send |
| tend_clr | input | 1 | Clears the transmit-end flag |
| tx_ie | input | 1 | Enable for the data-empty request |
| tend_ie | input | 1 | Enable for the transmit-end request |
| ovr_flag | input | 1 | Overrun flag from the receive side; holds off transmission |
| master_mode | input | 1 | 1 = clock master, 0 = select-gated slave |
| clk_pol | input | 1 | 0 = clock idles high, 1 = clock idles low |
| lsb_first | input | 1 | Bit order select |
| div_half | input | DIV_W | System cycles per serial clock half (master) |
| sclk_in | input | 1 | External serial clock (slave) |
| sel_n | input | 1 | Active-low select (slave) |
| sclk_out | output | 1 | Serial clock output |
| sclk_oe | output | 1 | Output enable for the serial clock |
| sdo | output | 1 | Serial data, 1 outside a frame |
| sdo_oe | output | 1 | Output enable for serial data |
| tde | output | 1 | Holding register empty |
| tend | output | 1 | Transmission ended |
| txi_irq | output | 1 | Data-empty interrupt request (level) |
| tei_irq | output | 1 | Transmit-end interrupt request (level) |

## Verification
The assertions assume the following about the inputs:
- `master_mode` and `clk_pol` stay fixed while a frame is in progress.
- `ovr_flag` only rises or falls between frames.
- In slave mode the external clock and the select change slowly compared with the synchroniser.

The stimulus changes the mode and polarity only once `tend` or the reset state shows the engine idle. It holds each external clock level for six system cycles. It moves the select only when the external clock rests at its idle level.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
   // Fewest synchroniser flops accepted for external clock and select.
   localparam int unsigned SSTX_MIN_SYNC = 2;

   // Resting level of the serial clock for a given polarity select.
   function automatic logic idle_level(input logic pol);
      return ~pol;
   endfunction
endpackage

// File: rtl/sstx_clkgen.sv
module sstx_clkgen
   import sstx_pkg::*;
#(
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             master,
   input  logic             run,
   input  logic             clk_pol,
   input  logic [DIV_W-1:0] div_half,
   input  logic             sclk_in,
   input  logic             sel_n_in,
   output logic             trail,
   output logic             sclk_out,
   output logic             sel_s
);
   logic                   idle;
   logic [SYNC_STAGES-1:0] sck_q;
   logic [SYNC_STAGES-1:0] sel_q;
   logic                   s_prev;
   logic                   s_cur;
   logic [DIV_W-1:0]       cnt;
   logic [DIV_W-1:0]       half;
   logic                   phase;
   logic                   term;

   assign idle = idle_level(clk_pol);

   // Synchroniser chain for the external clock and select.
   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_q[g] <= 1'b0;
               sel_q[g] <= 1'b1;
            end else begin
               sck_q[g] <= sclk_in;
               sel_q[g] <= sel_n_in;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_q[g] <= 1'b0;
               sel_q[g] <= 1'b1;
            end else begin
               sck_q[g] <= sck_q[g-1];
               sel_q[g] <= sel_q[g-1];
            end
         end
      end
   end

   assign s_cur = sck_q[SYNC_STAGES-1];
   assign sel_s = sel_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_prev <= 1'b0;
      else        s_prev <= s_cur;
   end

   // Master divider: phase 0 = idle half, phase 1 = active half.
   assign half = (div_half == '0) ? DIV_W'(1) : div_half;
   assign term = (cnt == half - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (!run || !master) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (term) begin
         cnt   <= '0;
         phase <= ~phase;
      end else begin
         cnt   <= cnt + DIV_W'(1);
      end
   end

   always_comb begin
      if (master) begin
         trail    = run & term & phase;
         sclk_out = idle ^ phase;
      end else begin
         trail    = run & (s_prev != idle) & (s_cur == idle);
         sclk_out = idle;
      end
   end
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         lsb_first,
   input  logic         advance,
   input  logic         abort,
   output logic         busy,
   output logic         bit_out,
   output logic         frame_done
);
   localparam int unsigned CNT_W = (W > 2) ? $clog2(W) : 1;

   logic [W-1:0]     sh;
   logic [CNT_W-1:0] cnt;

   assign frame_done = busy & advance & (cnt == CNT_W'(W-1));
   assign bit_out    = lsb_first ? sh[0] : sh[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         cnt  <= '0;
         busy <= 1'b0;
      end else if (abort) begin
         cnt  <= '0;
         busy <= 1'b0;
      end else if (load) begin
         sh   <= load_data;
         cnt  <= '0;
         busy <= 1'b1;
      end else if (busy && advance) begin
         sh <= lsb_first ? (sh >> 1) : (sh << 1);
         if (frame_done) begin
            cnt  <= '0;
            busy <= 1'b0;
         end else begin
            cnt  <= cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/sstx_engine.sv
module sstx_engine
   import sstx_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tend_clr,
   input  logic              tx_ie,
   input  logic              tend_ie,
   input  logic              ovr_flag,
   input  logic              master_mode,
   input  logic              clk_pol,
   input  logic              lsb_first,
   input  logic [DIV_W-1:0]  div_half,
   input  logic              sclk_in,
   input  logic              sel_n,
   output logic              sclk_out,
   output logic              sclk_oe,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              tde,
   output logic              tend,
   output logic              txi_irq,
   output logic              tei_irq
);
   if (DATA_W < 2) begin : g_bad_data_w
      $error("sstx_engine: DATA_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div_w
      $error("sstx_engine: DIV_W must be at least 1");
   end
   if (SYNC_STAGES < SSTX_MIN_SYNC) begin : g_bad_sync
      $error("sstx_engine: SYNC_STAGES below minimum");
   end

   logic [DATA_W-1:0] hold;
   logic              busy;
   logic              trail;
   logic              sel_s;
   logic              bit_out;
   logic              frame_done;
   logic              fin;
   logic              startable;
   logic              load;
   logic              abort;

   sstx_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .master   (master_mode),
      .run      (busy),
      .clk_pol  (clk_pol),
      .div_half (div_half),
      .sclk_in  (sclk_in),
      .sel_n_in (sel_n),
      .trail    (trail),
      .sclk_out (sclk_out),
      .sel_s    (sel_s)
   );

   sstx_shifter #(.W(DATA_W)) u_shifter (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_data  (hold),
      .lsb_first  (lsb_first),
      .advance    (trail),
      .abort      (abort),
      .busy       (busy),
      .bit_out    (bit_out),
      .frame_done (frame_done)
   );

   assign abort     = ~master_mode & busy & sel_s;
   assign fin       = frame_done & ~abort;
   assign startable = ~tde & ~ovr_flag & (master_mode | ~sel_s);
   assign load      = startable & (~busy | fin);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold <= '0;
         tde  <= 1'b1;
         tend <= 1'b0;
      end else begin
         if (wr_en)     hold <= wr_data;
         if (wr_en)     tde  <= 1'b0;
         else if (load) tde  <= 1'b1;
         if (wr_en || tend_clr)  tend <= 1'b0;
         else if (fin && tde)    tend <= 1'b1;
      end
   end

   assign sdo     = busy ? bit_out : 1'b1;
   assign sdo_oe  = master_mode | ~sel_s;
   assign sclk_oe = master_mode;
   assign txi_irq = tde & tx_ie;
   assign tei_irq = tend & tend_ie;
endmodule

// File: rtl/sstx_checks.sv
module sstx_checks (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic tend_clr,
   input logic ovr_flag,
   input logic master_mode,
   input logic clk_pol,
   input logic tde,
   input logic tend,
   input logic sclk_out,
   input logic busy,
   input logic sel_s
);
   assert_tde_falls_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tde) |-> $past(wr_en));

   assert_tend_rises_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tend) |-> ($past(tde) && $past(busy) && !busy));

   assert_tend_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || tend_clr) |=> !tend);

   assert_no_start_on_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !busy) |=> !busy);

   assert_idle_clock_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk_out == !clk_pol));

   assert_slave_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_mode && sel_s && $past(sel_s)) |-> !busy);
endmodule

bind sstx_engine sstx_checks u_checks (.*);

// File: tb/test_sstx_engine.sv
module test_sstx_engine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       tend_clr = 1'b0;
   logic       tx_ie = 1'b0;
   logic       tend_ie = 1'b0;
   logic       ovr_flag = 1'b0;
   logic       master_mode = 1'b1;
   logic       clk_pol = 1'b0;
   logic       lsb_first = 1'b0;
   logic [7:0] div_half = 8'd2;
   logic       sclk_in = 1'b1;
   logic       sel_n = 1'b1;
   logic       sclk_out, sclk_oe, sdo, sdo_oe, tde, tend, txi_irq, tei_irq;

   int checks = 0;
   int errors = 0;
   int last_active = 0;

   always #5 clk = ~clk;

   sstx_engine i_sstx_engine (.*);

   // data[13:6], lsb_first[5], clk_pol[4], div_half[3:0]
   localparam logic [13:0] VEC [0:5] = '{
      {8'hA5, 1'b0, 1'b0, 4'd2},
      {8'h3C, 1'b1, 1'b0, 4'd3},
      {8'h81, 1'b0, 1'b1, 4'd1},
      {8'h5E, 1'b1, 1'b1, 4'd4},
      {8'h01, 1'b0, 1'b0, 4'd0},
      {8'h96, 1'b1, 1'b1, 4'd2}
   };

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_byte(input logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1; wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Master: wait for the clock to leave idle, take sdo, measure the active half.
   task automatic get_bit(output logic b);
      do @(negedge clk); while (sclk_out == ~clk_pol);
      b = sdo;
      last_active = 0;
      while (sclk_out != ~clk_pol) begin
         last_active++;
         @(negedge clk);
      end
   endtask

   task automatic get_byte(output logic [7:0] v);
      logic bt;
      v = '0;
      for (int i = 0; i < 8; i++) begin
         get_bit(bt);
         if (lsb_first) v = {bt, v[7:1]};
         else           v = {v[6:0], bt};
      end
   endtask

   // Slave: external clock, pol 0 (idle high), six cycles per level.
   task automatic slave_bits(input int n, output logic [7:0] v);
      v = '0;
      for (int i = 0; i < n; i++) begin
         v = {v[6:0], sdo};
         sclk_in = 1'b0;
         repeat (6) @(negedge clk);
         sclk_in = 1'b1;
         repeat (6) @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] got;
      logic [7:0] got2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(tde == 1'b1, "R12 tde after reset", tde, 1);
      chk(tend == 1'b0, "R12 tend after reset", tend, 0);
      chk(sclk_out == 1'b1, "R12 idle clock after reset", sclk_out, 1);
      chk(txi_irq == 1'b0, "R3 no request with enable off", txi_irq, 0);
      tx_ie = 1'b1; tend_ie = 1'b1;
      @(negedge clk);
      chk(txi_irq == 1'b1, "R3 request with tde and enable", txi_irq, 1);
      chk(sclk_oe && sdo_oe, "R1 master drives clock and data", {sclk_oe, sdo_oe}, 3);

      // Table of master frames
      for (int k = 0; k < 6; k++) begin
         logic [7:0] exp_b;
         int exp_half;
         exp_b     = VEC[k][13:6];
         lsb_first = VEC[k][5];
         clk_pol   = VEC[k][4];
         div_half  = {4'd0, VEC[k][3:0]};
         exp_half  = (VEC[k][3:0] == 4'd0) ? 1 : int'(VEC[k][3:0]);
         @(negedge clk);
         chk(sclk_out == ~clk_pol, "R7 idle level before frame", sclk_out, ~clk_pol);
         @(negedge clk);
         wr_en = 1'b1; wr_data = exp_b;
         @(negedge clk);
         wr_en = 1'b0;
         chk(tde == 1'b0, "R2 write clears tde", tde, 0);
         chk(txi_irq == 1'b0, "R3 request drops with tde", txi_irq, 0);
         @(negedge clk);
         chk(tde == 1'b1, "R2 tde set again after load", tde, 1);
         get_byte(got);
         chk(got == exp_b, "R4 byte and bit order", got, exp_b);
         chk(last_active == exp_half, "R1 half period", last_active, exp_half);
         chk(tend == 1'b1, "R5 tend after last bit", tend, 1);
         chk(tei_irq == 1'b1, "R6 end request", tei_irq, 1);
         chk(sclk_out == ~clk_pol, "R7 idle level after frame", sclk_out, ~clk_pol);
         chk(sdo == 1'b1, "R4 data line rests high", sdo, 1);
         tend_clr = 1'b1;
         @(negedge clk);
         tend_clr = 1'b0;
         chk(tend == 1'b0 && tei_irq == 1'b0, "R5 tend cleared", {tend, tei_irq}, 0);
      end

      // R8 back-to-back frames
      clk_pol = 1'b0; lsb_first = 1'b0; div_half = 8'd2;
      write_byte(8'hC3);
      @(negedge clk);
      write_byte(8'h5A);
      get_byte(got);
      chk(tend == 1'b0, "R8 no tend between frames", tend, 0);
      chk(tde == 1'b1, "R8 second byte loaded at once", tde, 1);
      get_byte(got2);
      chk(got == 8'hC3, "R8 first byte", got, 8'hC3);
      chk(got2 == 8'h5A, "R8 second byte", got2, 8'h5A);
      chk(tend == 1'b1, "R5 tend after second frame", tend, 1);

      // R9 overrun holds off
      ovr_flag = 1'b1;
      write_byte(8'h77);
      chk(tend == 1'b0, "R5 write clears tend", tend, 0);
      begin
         int moved;
         moved = 0;
         repeat (40) begin
            @(negedge clk);
            if (sclk_out != 1'b1) moved++;
         end
         chk(moved == 0, "R9 clock idle during overrun", moved, 0);
      end
      chk(tde == 1'b0, "R9 byte still waiting", tde, 0);
      ovr_flag = 1'b0;
      get_byte(got);
      chk(got == 8'h77, "R9 byte sent after overrun cleared", got, 8'h77);
      tend_clr = 1'b1; @(negedge clk); tend_clr = 1'b0;

      // R10 slave mode
      master_mode = 1'b0; clk_pol = 1'b0; lsb_first = 1'b0;
      sclk_in = 1'b1; sel_n = 1'b1;
      write_byte(8'hB4);
      repeat (20) @(negedge clk);
      chk(tde == 1'b0, "R10 no start while deselected", tde, 0);
      chk(sdo_oe == 1'b0 && sclk_oe == 1'b0, "R10 outputs released", {sdo_oe, sclk_oe}, 0);
      sel_n = 1'b0;
      repeat (10) @(negedge clk);
      chk(tde == 1'b1, "R10 start when selected", tde, 1);
      chk(sdo_oe == 1'b1, "R10 data driven when selected", sdo_oe, 1);
      slave_bits(8, got);
      chk(got == 8'hB4, "R10 slave byte", got, 8'hB4);
      chk(tend == 1'b1, "R10 slave tend", tend, 1);

      // R11 abort mid-frame
      sel_n = 1'b1;
      tend_clr = 1'b1; @(negedge clk); tend_clr = 1'b0;
      write_byte(8'h0F);
      sel_n = 1'b0;
      repeat (10) @(negedge clk);
      slave_bits(3, got);
      sel_n = 1'b1;
      repeat (8) @(negedge clk);
      chk(sdo_oe == 1'b0, "R11 data released on abort", sdo_oe, 0);
      chk(tend == 1'b0, "R11 no tend on abort", tend, 0);
      write_byte(8'hE1);
      sel_n = 1'b0;
      repeat (10) @(negedge clk);
      slave_bits(8, got);
      chk(got == 8'hE1, "R11 next frame from first bit", got, 8'hE1);
      chk(tend == 1'b1, "R11 tend after full frame", tend, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule